// File: doc/BRIEF.md
# Jacobi Rotation Angle Sine/Cosine Generator

This block turns the four pivot entries of a symmetric matrix into the cosine and sine of the Jacobi rotation that zeroes the off-diagonal pair. It forms the tangent of twice the angle as the sum of the two off-diagonal entries over the difference of the two diagonal entries. A restoring divider computes that ratio one quotient bit per cycle. The ratio is mapped to an index into a 1024-entry sine/cosine table, and the table values come out in Q15.

An eigenvalue or SVD engine uses it once per pivot. The engine places the results into the rotation matrix: cosine on both diagonal positions, sine at row p / column q, negated sine at row q / column p. A one-cycle start request is accepted only while the unit reports ready. A one-cycle done pulse marks new outputs, which then hold until the next result.

The table covers half-angles between about −10° and +10°, so steeper ratios saturate to the end entries. The table is computed at elaboration. No file is read.

Top module: `jrot_param_unit`

## Requirements
- R1: After reset, ready is 1, done is 0 and all three angle outputs are 0.
- R2: start is accepted only while ready is 1. ready falls on the edge after an accepted start and stays low until done. A start while ready is 0 is ignored and changes neither the later result nor the number of done pulses.
- R3: done is a single-cycle pulse that is high exactly 12 clock edges (table index bits + 2) after the accepting edge. ready is 1 in that same cycle, and the outputs hold their value until the next done.
- R4: The inputs are 16-bit two's complement. With N = m_pq + m_qp and D = m_qq − m_pp, k = floor(|N|·1407 / |D|). When N and D have the same sign, the table index is 512 + min(k, 511). When their signs differ, the index is 512 − min(k, 512).
- R5: Table entry i holds the cosine and sine of θ = ½·atan((i − 512)/1407), scaled by 32768, rounded to nearest, and clamped to 32767. Every cosine delivered is at least the cosine at index 0.
- R6: When N is 0, the index is 512, so the cosine output is 32767 and the sine output is 0, whatever D is.
- R7: When D is 0 and N is not 0, the index is 1023 for positive N and 0 for negative N.
- R8: Ratios beyond the table span saturate: index 1023 for a positive ratio, index 0 for a negative one. This covers k exactly 512 with differing signs.
- R9: c_out carries the J(p,p)/J(q,q) value, s_out the J(p,q) value, and s_neg_out the J(q,p) value, which equals −s_out.
- R10: Full-scale inputs, including −32768, give a correct N and D without wrap-around. N and D are formed at 17 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to compute a rotation from the pivot inputs |
| m_pp | input | 16 | Diagonal entry at (p,p), signed |
| m_pq | input | 16 | Off-diagonal entry at (p,q), signed |
| m_qp | input | 16 | Off-diagonal entry at (q,p), signed |
| m_qq | input | 16 | Diagonal entry at (q,q), signed |
| ready | output | 1 | Unit idle, start will be accepted |
| done | output | 1 | One-cycle pulse: new outputs valid |
| c_out | output | 16 | Rotation cosine, Q15 |
| s_out | output | 16 | Rotation sine, Q15 |
| s_neg_out | output | 16 | Negated rotation sine, Q15 |

## Verification
A fault in the divider's remainder or shifted divisor shows up as a wrong table index. The sine and cosine therefore differ from the value predicted from the ratio on the very done pulse of that transaction, and saturation edge cases such as k of exactly 511 or 512 expose off-by-one errors. A stuck or miscounted sequencing state moves the done pulse away from edge 12, or makes ready stay low, which a counted latency check sees at once. A captured sign or zero flag that is wrong mirrors the result around index 512, so the sign of the sine output flips on the same pulse.

// File: rtl/jrot_pkg.sv
package jrot_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIV  = 2'd1,
      ST_LOOK = 2'd2
   } jrot_state_e;

   // Quantize a real value to a signed fixed-point integer with fbits fraction bits,
   // round to nearest, clamp to the representable range.
   function automatic int fx_quant(input real v, input int fbits);
      real s;
      int  r;
      int  hi;
      hi = (1 << fbits) - 1;
      s  = v * (2.0 ** fbits);
      if (s >= 0.0) r = $rtoi(s + 0.5);
      else          r = -$rtoi(0.5 - s);
      if (r > hi)       r = hi;
      if (r < -hi - 1)  r = -hi - 1;
      return r;
   endfunction

endpackage

// File: rtl/jrot_divider.sv
module jrot_divider #(
   parameter int DIVIDEND_W = 32,
   parameter int DIVISOR_W  = 20,
   parameter int QBITS      = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [DIVIDEND_W-1:0] dividend,
   input  logic [DIVISOR_W-1:0]  divisor,
   output logic [QBITS-1:0]      quot,
   output logic                  valid
);
   localparam int CNT_W = $clog2(QBITS + 1);

   generate
      if (QBITS < 2) begin : g_bad_q
         $error("jrot_divider: QBITS must be at least 2");
      end
      if (DIVISOR_W + QBITS > DIVIDEND_W) begin : g_bad_w
         $error("jrot_divider: shifted divisor does not fit the dividend width");
      end
   endgenerate

   logic [DIVIDEND_W-1:0] rem;
   logic [DIVIDEND_W-1:0] dsh;
   logic [CNT_W-1:0]      cnt;
   logic                  running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem     <= '0;
         dsh     <= '0;
         quot    <= '0;
         cnt     <= '0;
         running <= 1'b0;
         valid   <= 1'b0;
      end else if (load) begin
         rem     <= dividend;
         dsh     <= DIVIDEND_W'(divisor) << (QBITS - 1);
         quot    <= '0;
         cnt     <= CNT_W'(QBITS);
         running <= 1'b1;
         valid   <= 1'b0;
      end else if (running) begin
         if (rem >= dsh) begin
            rem  <= rem - dsh;
            quot <= {quot[QBITS-2:0], 1'b1};
         end else begin
            quot <= {quot[QBITS-2:0], 1'b0};
         end
         dsh <= dsh >> 1;
         cnt <= cnt - 1'b1;
         if (cnt == CNT_W'(1)) begin
            running <= 1'b0;
            valid   <= 1'b1;
         end
      end else begin
         valid <= 1'b0;
      end
   end

   // R4: restoring steps never grow the partial remainder
   assert_rem_mono_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !load) |=> rem <= $past(rem));

   // R3: quotient completion is a single-cycle event
   assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

endmodule

// File: rtl/jrot_sincos_rom.sv
module jrot_sincos_rom #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter int TSCALE = 1407
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   output logic signed [DATA_W-1:0] cos_o,
   output logic signed [DATA_W-1:0] sin_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HALF  = DEPTH / 2;

   typedef logic signed [DATA_W-1:0] tab_t [DEPTH];

   function automatic tab_t build_tab(input bit pick_sin);
      tab_t t;
      for (int i = 0; i < DEPTH; i++) begin
         real ratio;
         real ang;
         real v;
         ratio = real'(i - HALF) / real'(TSCALE);
         ang   = $atan(ratio) / 2.0;
         v     = pick_sin ? $sin(ang) : $cos(ang);
         t[i]  = DATA_W'(jrot_pkg::fx_quant(v, DATA_W - 1));
      end
      return t;
   endfunction

   localparam tab_t COS_TAB = build_tab(1'b0);
   localparam tab_t SIN_TAB = build_tab(1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cos_o <= '0;
         sin_o <= '0;
      end else if (rd_en) begin
         cos_o <= COS_TAB[addr];
         sin_o <= SIN_TAB[addr];
      end
   end

   // R5: a delivered cosine never falls below the table end value
   assert_cos_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> cos_o >= COS_TAB[0]);

   // R5: upper half of the table carries non-negative sine
   assert_sin_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr >= ADDR_W'(HALF)) |=> sin_o >= 0);

endmodule

// File: rtl/jrot_param_unit.sv
module jrot_param_unit #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 10,
   parameter int DIVIDEND_W = 32,
   parameter int DIVISOR_W  = 20,
   parameter int TSCALE     = 1407
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic signed [DATA_W-1:0] m_pp,
   input  logic signed [DATA_W-1:0] m_pq,
   input  logic signed [DATA_W-1:0] m_qp,
   input  logic signed [DATA_W-1:0] m_qq,
   output logic                     ready,
   output logic                     done,
   output logic signed [DATA_W-1:0] c_out,
   output logic signed [DATA_W-1:0] s_out,
   output logic signed [DATA_W-1:0] s_neg_out
);
   import jrot_pkg::*;

   localparam int SUM_W  = DATA_W + 1;
   localparam int HALF   = 1 << (ADDR_W - 1);
   localparam int TS_W   = $clog2(TSCALE + 1);

   generate
      if (DIVISOR_W < SUM_W) begin : g_bad_dvs
         $error("jrot_param_unit: divisor width cannot hold the diagonal difference");
      end
      if (SUM_W + TS_W > DIVIDEND_W) begin : g_bad_dvd
         $error("jrot_param_unit: scaled numerator overflows the dividend");
      end
      if (SUM_W + ADDR_W > DIVIDEND_W) begin : g_bad_ovf
         $error("jrot_param_unit: overflow probe does not fit the dividend");
      end
   endgenerate

   // R10: pivot sums formed one bit wider than the inputs
   logic signed [SUM_W-1:0] num_c, den_c;
   logic [SUM_W-1:0]        num_mag, den_mag;
   logic [DIVIDEND_W-1:0]   dvd_c;
   logic [DIVISOR_W-1:0]    dvs_c;
   logic                    ovf_c;
   logic                    accept;

   always_comb begin
      num_c   = SUM_W'(m_pq) + SUM_W'(m_qp);
      den_c   = SUM_W'(m_qq) - SUM_W'(m_pp);
      num_mag = num_c[SUM_W-1] ? SUM_W'(-num_c) : SUM_W'(num_c);
      den_mag = den_c[SUM_W-1] ? SUM_W'(-den_c) : SUM_W'(den_c);
      dvd_c   = DIVIDEND_W'(num_mag) * DIVIDEND_W'(TSCALE);
      dvs_c   = DIVISOR_W'(den_mag);
      ovf_c   = dvd_c >= (DIVIDEND_W'(dvs_c) << ADDR_W);
   end

   jrot_state_e         state;
   logic                neg_r, zero_r, ovf_r;
   logic [ADDR_W-1:0]   addr_r;
   logic [ADDR_W-1:0]   div_q;
   logic                div_valid;

   assign ready  = (state == ST_IDLE);
   assign accept = start && ready;

   jrot_divider #(
      .DIVIDEND_W(DIVIDEND_W),
      .DIVISOR_W (DIVISOR_W),
      .QBITS     (ADDR_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .dividend(dvd_c),
      .divisor (dvs_c),
      .quot    (div_q),
      .valid   (div_valid)
   );

   // table index from quotient, sign and saturation flags
   logic [ADDR_W:0]   k_c;
   logic [ADDR_W-1:0] addr_c;

   always_comb begin
      k_c = '0;
      if (zero_r) begin
         addr_c = ADDR_W'(HALF);
      end else if (neg_r) begin
         if (ovf_r || ({1'b0, div_q} > (ADDR_W+1)'(HALF))) k_c = (ADDR_W+1)'(HALF);
         else                                               k_c = {1'b0, div_q};
         addr_c = ADDR_W'((ADDR_W+1)'(HALF) - k_c);
      end else begin
         if (ovf_r || ({1'b0, div_q} > (ADDR_W+1)'(HALF - 1))) k_c = (ADDR_W+1)'(HALF - 1);
         else                                                   k_c = {1'b0, div_q};
         addr_c = ADDR_W'((ADDR_W+1)'(HALF) + k_c);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         neg_r  <= 1'b0;
         zero_r <= 1'b0;
         ovf_r  <= 1'b0;
         addr_r <= ADDR_W'(HALF);
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  neg_r  <= num_c[SUM_W-1] ^ den_c[SUM_W-1];
                  zero_r <= (num_c == '0);
                  ovf_r  <= ovf_c;
                  state  <= ST_DIV;
               end
            end
            ST_DIV: begin
               if (div_valid) begin
                  addr_r <= addr_c;
                  state  <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic signed [DATA_W-1:0] rom_cos, rom_sin;

   jrot_sincos_rom #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .TSCALE(TSCALE)
   ) u_rom (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_en(state == ST_LOOK),
      .addr (addr_r),
      .cos_o(rom_cos),
      .sin_o(rom_sin)
   );

   // R9: rotation entries
   assign c_out     = rom_cos;
   assign s_out     = rom_sin;
   assign s_neg_out = -rom_sin;

   // R3: done lasts one cycle
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: an accepted start makes the unit busy
   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready);

   // R3: the unit is idle again when the result appears
   assert_ready_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   // R4: a negative ratio never selects the upper half
   assert_neg_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOOK && neg_r && !zero_r) |-> addr_r <= ADDR_W'(HALF));

endmodule

// File: tb/sim_jrot_param_unit.sv
`timescale 1ns/1ps
module sim_jrot_param_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic signed [15:0] m_pp = '0, m_pq = '0, m_qp = '0, m_qq = '0;
   logic ready, done;
   logic signed [15:0] c_out, s_out, s_neg_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   jrot_param_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .m_pp(m_pp), .m_pq(m_pq), .m_qp(m_qp), .m_qq(m_qq),
      .ready(ready), .done(done),
      .c_out(c_out), .s_out(s_out), .s_neg_out(s_neg_out)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !finished) begin
         failures = failures + 1;
         $display("FAIL watchdog: run did not complete (actual=%0d cycles, expected < 20000)", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp, input int tol);
      int d;
      checks = checks + 1;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected index per R4/R6/R7/R8
   function automatic int exp_idx(input int pp, input int pq, input int qp, input int qq);
      longint num, den, an, ad, k;
      num = longint'(pq) + longint'(qp);
      den = longint'(qq) - longint'(pp);
      if (num == 0) return 512;
      an = (num < 0) ? -num : num;
      ad = (den < 0) ? -den : den;
      if (ad == 0) k = 64'd1 << 30;
      else         k = (an * 1407) / ad;
      if ((num < 0) != (den < 0)) begin
         if (k > 512) k = 512;
         return 512 - int'(k);
      end
      if (k > 511) k = 511;
      return 512 + int'(k);
   endfunction

   // expected Q15 value per R5
   function automatic int exp_val(input int idx, input bit want_sin);
      real th, v;
      int r;
      th = $atan(real'(idx - 512) / 1407.0) / 2.0;
      v  = (want_sin ? $sin(th) : $cos(th)) * 32768.0;
      r  = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
      if (r > 32767) r = 32767;
      return r;
   endfunction

   // one transaction; checks latency (R3), done pulse (R3), values (R5, R9)
   task automatic run_case(input string req, input int pp, input int pq, input int qp, input int qq);
      int lat, idx;
      @(negedge clk);
      m_pp = 16'(pp); m_pq = 16'(pq); m_qp = 16'(qp); m_qq = 16'(qq);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R2 ready low after accept", int'(ready), 0, 0);
      lat = 0;
      while (!done && lat < 100) begin
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      check("R3 latency", lat, 12, 0);
      idx = exp_idx(pp, pq, qp, qq);
      check({req, " cos"}, int'(c_out), exp_val(idx, 1'b0), 1);
      check({req, " sin"}, int'(s_out), exp_val(idx, 1'b1), 1);
      check("R9 neg sin", int'(s_neg_out), -int'(s_out), 0);
      @(negedge clk);
      check("R3 done single cycle", int'(done), 0, 0);
   endtask

   task automatic t_reset();
      check("R1 ready", int'(ready), 1, 0);
      check("R1 done", int'(done), 0, 0);
      check("R1 cos", int'(c_out), 0, 0);
      check("R1 sin", int'(s_out), 0, 0);
      check("R1 neg sin", int'(s_neg_out), 0, 0);
   endtask

   task automatic t_ratios();
      run_case("R4 pos ratio", 1000, 300, 300, 5000);
      run_case("R4 neg num", 2000, -500, -500, 9000);
      run_case("R4 neg den", 8000, 200, 100, 1000);
      run_case("R4 small", 0, 1, 0, 30000);
   endtask

   task automatic t_zero_num();
      run_case("R6 zero num", 500, 100, -100, -700);
      check("R6 cos one", int'(c_out), 32767, 0);
      check("R6 sin zero", int'(s_out), 0, 0);
   endtask

   task automatic t_zero_den();
      run_case("R7 zero den pos", 1234, 10, 10, 1234);
      check("R7 sin positive end", int'(s_out), exp_val(1023, 1'b1), 1);
      run_case("R7 zero den neg", -77, -10, -3, -77);
      check("R7 sin negative end", int'(s_out), exp_val(0, 1'b1), 1);
   endtask

   task automatic t_saturate();
      run_case("R8 big pos", 0, 10000, 10000, 100);
      run_case("R8 big neg", 0, -10000, -10000, 100);
      run_case("R8 k512 neg", 1407, 256, 256, 0);
      check("R8 k512 neg idx0", int'(s_out), exp_val(0, 1'b1), 1);
      run_case("R8 k512 pos", 0, 256, 256, 1407);
      check("R8 k512 pos idx1023", int'(s_out), exp_val(1023, 1'b1), 1);
      run_case("R8 k511 pos", 0, 511, 0, 1407);
   endtask

   task automatic t_extremes();
      run_case("R10 min num", 32767, -32768, -32768, -32768);
      run_case("R10 max sum", -32768, 32767, 32767, 32767);
      run_case("R10 wide den", -32768, -8000, -8000, 32767);
   endtask

   task automatic t_busy_ignore();
      int lat, idx, extra;
      @(negedge clk);
      m_pp = 16'sd1000; m_pq = 16'sd300; m_qp = 16'sd300; m_qq = 16'sd5000;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      repeat (3) begin @(posedge clk); @(negedge clk); lat++; end
      m_pp = 16'sd0; m_pq = -16'sd9000; m_qp = -16'sd9000; m_qq = 16'sd10;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      lat++;
      start = 1'b0;
      check("R2 still busy", int'(ready), 0, 0);
      while (!done && lat < 100) begin
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      check("R2 latency of first request", lat, 12, 0);
      idx = exp_idx(1000, 300, 300, 5000);
      check("R2 busy start ignored cos", int'(c_out), exp_val(idx, 1'b0), 1);
      check("R2 busy start ignored sin", int'(s_out), exp_val(idx, 1'b1), 1);
      extra = 0;
      repeat (20) begin
         @(posedge clk);
         @(negedge clk);
         if (done) extra++;
      end
      check("R2 no second done", extra, 0, 0);
   endtask

   task automatic t_hold();
      int c0, s0;
      c0 = int'(c_out);
      s0 = int'(s_out);
      @(negedge clk);
      m_pp = 16'sd5; m_pq = 16'sd4000; m_qp = 16'sd4000; m_qq = 16'sd9;
      repeat (8) @(negedge clk);
      check("R3 cos held", int'(c_out), c0, 0);
      check("R3 sin held", int'(s_out), s0, 0);
      check("R3 ready idle", int'(ready), 1, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_ratios();
      t_zero_num();
      t_zero_den();
      t_saturate();
      t_extremes();
      t_busy_ignore();
      t_hold();
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule